// File: doc/BRIEF.md
# Serial Configuration Register Slave with Pulse Polarity Normalizer

This block receives configuration words over a three-wire serial link (clock, active-low enable, data) and keeps three small registers: a gain code, an overflow-drain level code and a polarity word. A write is a 16-bit frame, most significant bit first: a 4-bit register address followed by 12 data bits. Bits are sampled while the enable is low. The frame is held back until one more serial clock arrives after the enable has gone high again, and it is committed to the register bank on that clock. The gain and level codes are exported as raw 8-bit values. The gain code is linear in dB: code 0 is 0 dB, 64 is 6 dB, 128 is 12 dB, 192 is 18 dB and 255 is 24 dB. The level code spans 0 V at code 0 to 1.0 V at code 255. The analog stages that use these codes lie outside this block.

The polarity word sets how seven external timing inputs are read: the two correlated-sampling pulses, the dummy-pixel clamp, the optical-black clamp, blanking, the pixel-clock phase reference and vertical sync. Each input is turned into an active-high strobe in the pixel clock domain. That strobe rises on the selected active level or edge, whichever way the source drives it.

Top module: `sercfg_slave`

## Requirements
- R1: A frame is the ser_dat values sampled on rising ser_clk edges while ser_en_n is low, first bit first. The first 4 bits form the address (MSB first) and the next 12 bits form the data (D11 first).
- R2: A 16-bit frame changes a register only on the first rising ser_clk with ser_en_n high after the frame. Until that edge, gain_code, ofd_code and pol_word keep their old values.
- R3: A frame of any length other than 16 bits is discarded and changes no register.
- R4: Address 0x0 loads gain_code with data bits 7..0. Data bits 11..8 are ignored.
- R5: Address 0x1 loads ofd_code with data bits 7..0. Data bits 11..8 are ignored.
- R6: Address 0x3 loads pol_word with data bits 9..0.
- R7: A frame to any other address (0x2, 0x4 to 0xF) changes no register.
- R8: While rst is high, gain_code and ofd_code become 0, pol_word becomes 0x2FE and pulse_act becomes 0. rst is synchronous and must be held across edges of both clocks.
- R9: pulse_act[i] is pulse_raw[i] XOR inv[i]. Channels 0 and 1 (sampling pulses) invert when pol bit 4 is 0. Channel 2 (dummy clamp) inverts when bit 0 is 1. Channel 3 (black clamp) inverts when bit 1 is 0. Channel 4 (blanking) inverts when bit 3 is 0. Channel 5 (pixel-clock phase) inverts when bit 5 is 0. Channel 6 (vertical sync) inverts when bit 8 is 1.
- R10: pulse_act is registered once on clk_pix. The polarity word reaches it through a two-stage clk_pix synchronizer, so a new pol_word acts within three clk_pix cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock for the pulse normalizer |
| rst | input | 1 | Synchronous active-high reset, both domains |
| ser_clk | input | 1 | Serial link clock |
| ser_en_n | input | 1 | Serial frame enable, active low |
| ser_dat | input | 1 | Serial data, sampled on rising ser_clk |
| pulse_raw | input | 7 | External timing pulses, channel order as in R9 |
| gain_code | output | 8 | Gain code (linear in dB, 0 to 24 dB) |
| ofd_code | output | 8 | Overflow-drain level code (0 to 1.0 V) |
| pol_word | output | 10 | Polarity register |
| pulse_act | output | 7 | Normalized active-high strobes |

## Verification
The bench stops a frame just before its trailing clock and checks that nothing has been written yet. A design that commits on the rising enable, or on the last data bit, fails at this point. It sends 15- and 17-bit frames; a receiver that keeps the last 16 bits or only counts to 16 would write from them. Writes with high data bits set show whether the gain or level register keeps bits it should drop, and writes to undefined addresses catch a decoder that aliases on part of the address. After each polarity change the bench compares all seven strobes against a model. This catches a swapped or inverted polarity bit and a synchronizer that never passes the new word on.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 12;
    localparam int CODE_W = 8;
    localparam int POL_W  = 10;
    localparam int NCH    = 7;
    localparam int SYNC_N = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_GAIN = 4'h0,
        RA_OFD  = 4'h1,
        RA_POL  = 4'h3
    } reg_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam int FRAME_W = $bits(frame_t);

    // polarity word bit positions (decoded by the normalizer)
    localparam int PB_DMCLAMP = 0;
    localparam int PB_OBCLAMP = 1;
    localparam int PB_BLANK   = 3;
    localparam int PB_SAMPLE  = 4;
    localparam int PB_PIXEDGE = 5;
    localparam int PB_VSEDGE  = 8;

    // active-high levels, rising edges, fixed bits set
    localparam logic [POL_W-1:0] POL_RESET = 10'h2FE;

    // per-channel inversion derived from the polarity word
    function automatic logic [NCH-1:0] pulse_invert(input logic [POL_W-1:0] p);
        logic [NCH-1:0] m;
        m[0] = ~p[PB_SAMPLE];
        m[1] = ~p[PB_SAMPLE];
        m[2] =  p[PB_DMCLAMP];
        m[3] = ~p[PB_OBCLAMP];
        m[4] = ~p[PB_BLANK];
        m[5] = ~p[PB_PIXEDGE];
        m[6] =  p[PB_VSEDGE];
        return m;
    endfunction

endpackage

// File: rtl/sercfg_shift.sv
module sercfg_shift
    import sercfg_pkg::*;
#(
    parameter int FW = FRAME_W,
    localparam int CNT_W = $clog2(FW + 2)
) (
    input  logic             ser_clk,
    input  logic             rst,
    input  logic             ser_en_n,
    input  logic             ser_dat,
    output frame_t           frm,
    output logic             commit,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             in_frame
);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);

    logic [FW-1:0] sh;

    always_ff @(posedge ser_clk) begin
        if (rst) begin
            sh       <= '0;
            bit_cnt  <= '0;
            in_frame <= 1'b0;
        end else if (!ser_en_n) begin
            sh       <= {sh[FW-2:0], ser_dat};
            in_frame <= 1'b1;
            if (bit_cnt != CNT_SAT)
                bit_cnt <= bit_cnt + 1'b1;
        end else begin
            bit_cnt  <= '0;
            in_frame <= 1'b0;
        end
    end

    assign frm    = frame_t'(sh);
    assign commit = ser_en_n && in_frame && (bit_cnt == CNT_FULL);

endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
    import sercfg_pkg::*;
(
    input  logic              ser_clk,
    input  logic              rst,
    input  logic              commit,
    input  frame_t            frm,
    output logic [CODE_W-1:0] gain_code,
    output logic [CODE_W-1:0] ofd_code,
    output logic [POL_W-1:0]  pol_word
);
    always_ff @(posedge ser_clk) begin
        if (rst) begin
            gain_code <= '0;
            ofd_code  <= '0;
            pol_word  <= POL_RESET;
        end else if (commit) begin
            case (frm.addr)
                RA_GAIN: gain_code <= frm.data[CODE_W-1:0];
                RA_OFD:  ofd_code  <= frm.data[CODE_W-1:0];
                RA_POL:  pol_word  <= frm.data[POL_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sercfg_pulse_norm.sv
module sercfg_pulse_norm
    import sercfg_pkg::*;
#(
    parameter int N  = NCH,
    parameter int PW = POL_W,
    parameter int SN = SYNC_N
) (
    input  logic          clk_pix,
    input  logic          rst,
    input  logic [PW-1:0] pol_in,
    input  logic [N-1:0]  raw,
    output logic [N-1:0]  act,
    output logic [PW-1:0] pol_q
);
    logic [PW-1:0] stage [SN];
    logic [N-1:0]  inv;

    always_ff @(posedge clk_pix) begin
        if (rst) begin
            for (int s = 0; s < SN; s++) stage[s] <= POL_RESET;
        end else begin
            stage[0] <= pol_in;
            for (int s = 1; s < SN; s++) stage[s] <= stage[s-1];
        end
    end

    assign pol_q = stage[SN-1];
    assign inv   = pulse_invert(pol_q);

    for (genvar ch = 0; ch < N; ch++) begin : g_ch
        logic q;
        always_ff @(posedge clk_pix) begin
            if (rst) q <= 1'b0;
            else     q <= raw[ch] ^ inv[ch];
        end
        assign act[ch] = q;
    end

endmodule

// File: rtl/sercfg_slave.sv
module sercfg_slave
    import sercfg_pkg::*;
(
    input  logic              clk_pix,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_en_n,
    input  logic              ser_dat,
    input  logic [NCH-1:0]    pulse_raw,
    output logic [CODE_W-1:0] gain_code,
    output logic [CODE_W-1:0] ofd_code,
    output logic [POL_W-1:0]  pol_word,
    output logic [NCH-1:0]    pulse_act
);
    localparam int CNT_W = $clog2(FRAME_W + 2);

    frame_t           frm;
    logic             commit;
    logic [CNT_W-1:0] bit_cnt;
    logic             in_frame;
    logic [POL_W-1:0] pol_sync;

    sercfg_shift #(.FW(FRAME_W)) u_shift (
        .ser_clk (ser_clk),
        .rst     (rst),
        .ser_en_n(ser_en_n),
        .ser_dat (ser_dat),
        .frm     (frm),
        .commit  (commit),
        .bit_cnt (bit_cnt),
        .in_frame(in_frame)
    );

    sercfg_regbank u_regs (
        .ser_clk  (ser_clk),
        .rst      (rst),
        .commit   (commit),
        .frm      (frm),
        .gain_code(gain_code),
        .ofd_code (ofd_code),
        .pol_word (pol_word)
    );

    sercfg_pulse_norm #(.N(NCH), .PW(POL_W), .SN(SYNC_N)) u_norm (
        .clk_pix(clk_pix),
        .rst    (rst),
        .pol_in (pol_word),
        .raw    (pulse_raw),
        .act    (pulse_act),
        .pol_q  (pol_sync)
    );

endmodule

// File: rtl/sercfg_checks.sv
module sercfg_checks
    import sercfg_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_W + 2)
) (
    input logic              clk_pix,
    input logic              rst,
    input logic              ser_clk,
    input logic              commit,
    input logic              ser_en_n,
    input logic              in_frame,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [ADDR_W-1:0] frm_addr,
    input logic [DATA_W-1:0] frm_data,
    input logic [CODE_W-1:0] gain_code,
    input logic [CODE_W-1:0] ofd_code,
    input logic [POL_W-1:0]  pol_word,
    input logic [POL_W-1:0]  pol_sync,
    input logic [NCH-1:0]    pulse_raw,
    input logic [NCH-1:0]    pulse_act
);
    AST_HOLD_NO_COMMIT: assert property (@(posedge ser_clk) disable iff (rst)
        !commit |=> $stable(gain_code) && $stable(ofd_code) && $stable(pol_word)); // R2

    AST_BAD_LENGTH: assert property (@(posedge ser_clk) disable iff (rst)
        ser_en_n && in_frame && (bit_cnt != CNT_W'(FRAME_W))
        |=> $stable(gain_code) && $stable(ofd_code) && $stable(pol_word)); // R3

    AST_GAIN_LOAD: assert property (@(posedge ser_clk) disable iff (rst)
        commit && (frm_addr == 4'h0) |=> gain_code == $past(frm_data[7:0])); // R4

    AST_OFD_LOAD: assert property (@(posedge ser_clk) disable iff (rst)
        commit && (frm_addr == 4'h1) |=> ofd_code == $past(frm_data[7:0])); // R5

    AST_POL_LOAD: assert property (@(posedge ser_clk) disable iff (rst)
        commit && (frm_addr == 4'h3) |=> pol_word == $past(frm_data[9:0])); // R6

    AST_UNDEF_ADDR: assert property (@(posedge ser_clk) disable iff (rst)
        commit && (frm_addr != 4'h0) && (frm_addr != 4'h1) && (frm_addr != 4'h3)
        |=> $stable(gain_code) && $stable(ofd_code) && $stable(pol_word)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk_pix) disable iff (rst)
        $past(rst) |-> pulse_act == '0); // R8

    AST_DEFAULT_PASS: assert property (@(posedge clk_pix) disable iff (rst)
        !$past(rst) && ($past(pol_sync) == POL_RESET) |-> pulse_act == $past(pulse_raw)); // R10

endmodule

bind sercfg_slave sercfg_checks u_chk (
    .clk_pix  (clk_pix),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .commit   (commit),
    .ser_en_n (ser_en_n),
    .in_frame (in_frame),
    .bit_cnt  (bit_cnt),
    .frm_addr (frm.addr),
    .frm_data (frm.data),
    .gain_code(gain_code),
    .ofd_code (ofd_code),
    .pol_word (pol_word),
    .pol_sync (pol_sync),
    .pulse_raw(pulse_raw),
    .pulse_act(pulse_act)
);

// File: tb/sim_sercfg_slave.sv
`timescale 1ns/1ps
module sim_sercfg_slave;

    logic       clk_pix = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_dat = 1'b0;
    logic [6:0] pulse_raw = '0;
    logic [7:0] gain_code;
    logic [7:0] ofd_code;
    logic [9:0] pol_word;
    logic [6:0] pulse_act;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_gain;
    logic [7:0] m_ofd;
    logic [9:0] m_pol;

    always #5 clk_pix = ~clk_pix;

    sercfg_slave u0 (
        .clk_pix  (clk_pix),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_en_n (ser_en_n),
        .ser_dat  (ser_dat),
        .pulse_raw(pulse_raw),
        .gain_code(gain_code),
        .ofd_code (ofd_code),
        .pol_word (pol_word),
        .pulse_act(pulse_act)
    );

    function automatic logic [6:0] exp_inv(input logic [9:0] p);
        logic [6:0] m;
        m[0] = (p[4] == 1'b0);
        m[1] = (p[4] == 1'b0);
        m[2] = (p[0] == 1'b1);
        m[3] = (p[1] == 1'b0);
        m[4] = (p[3] == 1'b0);
        m[5] = (p[5] == 1'b0);
        m[6] = (p[8] == 1'b1);
        return m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk({req, " gain"}, 32'(gain_code), 32'(m_gain));
        chk({req, " ofd"},  32'(ofd_code),  32'(m_ofd));
        chk({req, " pol"},  32'(pol_word),  32'(m_pol));
    endtask

    task automatic ser_edge();
        #10 ser_clk = 1'b1;
        #10 ser_clk = 1'b0;
    endtask

    // send nbits of val MSB first; optionally the trailing commit clock
    task automatic send(input int nbits, input logic [31:0] val, input bit trail);
        ser_clk = 1'b0;
        #5 ser_en_n = 1'b0;
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_clk = 1'b0;
            ser_dat = val[i];
            #10 ser_clk = 1'b1;
            #10;
        end
        #5 ser_en_n = 1'b1;
        #5 ser_clk = 1'b0;
        #10;
        if (trail) ser_edge();
    endtask

    function automatic void model_apply(input logic [3:0] a, input logic [11:0] d);
        case (a)
            4'h0: m_gain = d[7:0];
            4'h1: m_ofd  = d[7:0];
            4'h3: m_pol  = d[9:0];
            default: ;
        endcase
    endfunction

    task automatic write(input logic [3:0] a, input logic [11:0] d);
        send(16, {16'h0, a, d}, 1'b1);
        model_apply(a, d);
    endtask

    task automatic check_pulses(input string req, input int n);
        repeat (4) @(negedge clk_pix);
        for (int k = 0; k < n; k++) begin
            logic [6:0] r;
            r = 7'($urandom);
            @(negedge clk_pix) pulse_raw = r;
            @(negedge clk_pix);
            chk(req, 32'(pulse_act), 32'(r ^ exp_inv(m_pol)));
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_gain = 8'h00; m_ofd = 8'h00; m_pol = 10'h2FE;
        repeat (3) ser_edge();
        repeat (4) @(negedge clk_pix);
        rst = 1'b0;
        @(negedge clk_pix);

        // R8 reset values
        check_regs("R8 reset");
        chk("R8 pulse reset", 32'(pulse_act), 32'h0);
        check_pulses("R9 R10 default polarity passes through", 4);

        // R1 R4 gain with upper data bits ignored
        write(4'h0, 12'hF40);
        check_regs("R1 R4 gain write");
        write(4'h0, 12'h0FF);
        check_regs("R4 gain full scale");

        // R5 level register
        write(4'h1, 12'hA80);
        check_regs("R5 ofd write");

        // R2 commit deferred until trailing clock
        send(16, {16'h0, 4'h0, 12'h0C0}, 1'b0);
        #30;
        check_regs("R2 no trailing clock holds");
        ser_edge();
        model_apply(4'h0, 12'h0C0);
        check_regs("R2 trailing clock commits");

        // R3 wrong lengths
        send(15, 32'h0_011, 1'b1);
        check_regs("R3 15-bit frame dropped");
        send(17, 32'h0_0055, 1'b1);
        check_regs("R3 17-bit frame dropped");
        send(17, 32'h1_0033, 1'b1);
        check_regs("R3 17-bit frame with valid tail dropped");

        // R7 undefined addresses
        write(4'h2, 12'hFFF);
        check_regs("R7 addr 2 ignored");
        write(4'hB, 12'h123);
        check_regs("R7 addr B ignored");
        write(4'h8, 12'h301);
        check_regs("R7 addr 8 ignored");

        // R6 R9 polarity variants
        write(4'h3, 12'h3FF);
        check_regs("R6 pol all ones");
        check_pulses("R9 pol 3FF", 4);
        write(4'h3, 12'h000);
        check_regs("R6 pol zero");
        check_pulses("R9 pol 000", 4);
        write(4'h3, 12'hD2E);
        check_regs("R6 pol upper bits dropped");
        check_pulses("R9 R10 pol 12E", 4);

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            logic [3:0]  a;
            logic [11:0] d;
            int sel;
            sel = int'($urandom_range(0, 9));
            a = (sel < 3) ? 4'h0 : (sel < 5) ? 4'h1 : (sel < 8) ? 4'h3 : 4'($urandom);
            d = 12'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                send(($urandom_range(0, 1) == 0) ? 14 : 18, {16'h0, a, d}, 1'b1);
                check_regs("R3 random bad length");
            end else begin
                write(a, d);
                check_regs("R1 random write");
                if (a == 4'h3) check_pulses("R9 R10 random polarity", 2);
            end
        end

        // R8 reset restores defaults after writes
        rst = 1'b1;
        repeat (2) ser_edge();
        repeat (3) @(negedge clk_pix);
        rst = 1'b0;
        m_gain = 8'h00; m_ofd = 8'h00; m_pol = 10'h2FE;
        @(negedge clk_pix);
        check_regs("R8 reset after writes");
        check_pulses("R8 R9 defaults after reset", 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule